// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits inside a small processor core and decides, at each instruction boundary, whether to divert execution into an interrupt handler. When it takes an interrupt it captures the current program counter, works out the handler address, and hands that address to the fetch logic. While it works it holds a busy flag that stalls instruction fetch. A later return instruction makes the unit load the captured program counter back.

Each maskable entry computes the handler address in one of three ways. In fixed mode a built-in constant is used. In vectored mode an acknowledge is raised for one cycle and the address is taken from the data bus. In table mode the same acknowledge is raised, the data bus carries a small index, and the address is read from a table in memory. A separate non-maskable input is edge-latched. It wins over the maskable request, ignores the mask and uses its own constant address. Entry to a maskable handler sets the mask automatically, and the return clears it again.

Top module: `irq_sequencer`

## Requirements
- R1: An interrupt or return is acted on only in a cycle where `instr_done` is high and `busy` is low; with `instr_done` low a pending `irq` starts nothing.
- R2: In the first cycle after an interrupt is taken `save_pc` is high for one cycle, and `saved_pc` holds the `pc_in` value present at the boundary.
- R3: With `mode` = 0 (fixed), a taken `irq` gives `load_pc` one cycle after the boundary with `target_pc` = FIXED_ADDR (default 16), and `irq_ack` stays low.
- R4: With `mode` = 1 (vectored), `irq_ack` is high for exactly the one cycle after the boundary. `data_bus` is sampled at the end of that cycle, and the next cycle shows `load_pc` with that value as `target_pc`.
- R5: With `mode` = 2 (table), `irq_ack` is high for one cycle and `data_bus[7:0]` is sampled at its end as an index from 0 to 255. The upper bits are ignored. The next cycle shows `tbl_rd_en` with `tbl_addr` = TABLE_BASE (default 0x0100) + index. The word on `tbl_rd_data` one cycle later is presented as `target_pc` with `load_pc`.
- R6: `mask_wr` loads `mask_din` into the mask, which is visible on `int_masked`. While the mask is 1, `irq` is ignored at boundaries.
- R7: A rising edge on `nmi` is latched. At the next boundary it is taken whatever the mask or mode: `load_pc` comes one cycle later with `target_pc` = NMI_ADDR (default 8), and no acknowledge is raised.
- R8: When a latched `nmi` and `irq` are both present at a boundary, the non-maskable request is taken.
- R9: Taking `irq` sets the mask, and returning from that handler restores the mask it replaced. While a non-maskable handler is active, `irq` is not taken.
- R10: `ret` with `instr_done` makes the next cycle show `load_pc` with the captured PC of the innermost active handler (non-maskable before maskable) and no `save_pc`. With no handler active, `ret` has no effect.
- R11: `busy` is high from the cycle after a taken boundary through the `load_pc` cycle inclusive, and low otherwise. Fixed and non-maskable entries are busy for 1 cycle, vectored for 2 and table for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Address source for maskable entries: 0 fixed, 1 vectored, 2 table |
| mask_wr | input | 1 | Write strobe for the mask bit |
| mask_din | input | 1 | Mask value to write |
| irq | input | 1 | Maskable request, level sensitive |
| nmi | input | 1 | Non-maskable request, rising-edge latched |
| instr_done | input | 1 | Current instruction has completed |
| ret | input | 1 | The completing instruction is a return from interrupt |
| pc_in | input | AW | Program counter at the boundary |
| data_bus | input | DW | Bus carrying the vector or the table index |
| tbl_rd_data | input | AW | Table word, valid one cycle after `tbl_rd_en` |
| irq_ack | output | 1 | Interrupt acknowledge |
| tbl_rd_en | output | 1 | Table read request |
| tbl_addr | output | AW | Table read address |
| save_pc | output | 1 | Strobe: `saved_pc` holds a new value |
| saved_pc | output | AW | Captured program counter |
| load_pc | output | 1 | Strobe: fetch must jump to `target_pc` |
| target_pc | output | AW | Handler or return address |
| busy | output | 1 | Sequence in progress; stalls fetch |
| int_masked | output | 1 | Current mask bit |

## Verification
Some properties are checked on every cycle. The acknowledge never lasts two cycles. `load_pc` only appears while busy. A table read is always followed by a load. A captured PC always matches the PC at the boundary. A masked request never starts a sequence, and a latched non-maskable request at an idle boundary always produces an immediate jump to its address. The bench scenarios are needed for the rest: the exact addresses delivered by each mode, the table index arithmetic at indices 7 and 255, NMI priority over a simultaneous request, the automatic mask across entry and return, nested returns in the right order, and a return with no active handler.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IDXW = 8,
  parameter logic [AW-1:0] FIXED_ADDR = 16,
  parameter logic [AW-1:0] NMI_ADDR = 8,
  parameter logic [AW-1:0] TABLE_BASE = 'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          mask_wr,
  input  logic          mask_din,
  input  logic          irq,
  input  logic          nmi,
  input  logic          instr_done,
  input  logic          ret,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] data_bus,
  input  logic [AW-1:0] tbl_rd_data,
  output logic          irq_ack,
  output logic          tbl_rd_en,
  output logic [AW-1:0] tbl_addr,
  output logic          save_pc,
  output logic [AW-1:0] saved_pc,
  output logic          load_pc,
  output logic [AW-1:0] target_pc,
  output logic          busy,
  output logic          int_masked
);
  localparam logic [1:0] M_FIXED = 2'd0;
  localparam logic [1:0] M_VECT  = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_TBL, S_LOAD} st_t;

  st_t            st;
  logic           nmi_q, nmi_pend, mask_q, mask_sv, in_int, in_nmi;
  logic           from_tbl, save_q;
  logic [1:0]     seq_mode;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]  int_pc, nmi_pc, tgt_q, spc_q;

  wire boundary = (st == S_IDLE) && instr_done;
  wire take_ret = boundary && ret && (in_int || in_nmi);
  wire take_nmi = boundary && !ret && nmi_pend && !in_nmi;
  wire take_int = boundary && !ret && !take_nmi && irq && !mask_q && !in_nmi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      nmi_q <= 1'b0;
      nmi_pend <= 1'b0;
      mask_q <= 1'b0;
      mask_sv <= 1'b0;
      in_int <= 1'b0;
      in_nmi <= 1'b0;
      from_tbl <= 1'b0;
      save_q <= 1'b0;
      seq_mode <= M_FIXED;
      idx_q <= '0;
      int_pc <= '0;
      nmi_pc <= '0;
      tgt_q <= '0;
      spc_q <= '0;
    end else begin
      nmi_q <= nmi;
      nmi_pend <= (nmi && !nmi_q) || (nmi_pend && !take_nmi);
      save_q <= take_nmi || take_int;
      if (take_nmi || take_int) spc_q <= pc_in;

      if (take_int) mask_q <= 1'b1;
      else if (take_ret && !in_nmi) mask_q <= mask_sv;
      else if (mask_wr) mask_q <= mask_din;

      case (st)
        S_IDLE: begin
          if (take_nmi) begin
            nmi_pc <= pc_in;
            in_nmi <= 1'b1;
            tgt_q <= NMI_ADDR;
            from_tbl <= 1'b0;
            st <= S_LOAD;
          end else if (take_int) begin
            int_pc <= pc_in;
            in_int <= 1'b1;
            mask_sv <= mask_q;
            seq_mode <= mode;
            from_tbl <= 1'b0;
            if (mode == M_FIXED) begin
              tgt_q <= FIXED_ADDR;
              st <= S_LOAD;
            end else begin
              st <= S_ACK;
            end
          end else if (take_ret) begin
            from_tbl <= 1'b0;
            st <= S_LOAD;
            if (in_nmi) begin
              tgt_q <= nmi_pc;
              in_nmi <= 1'b0;
            end else begin
              tgt_q <= int_pc;
              in_int <= 1'b0;
            end
          end
        end
        S_ACK: begin
          if (seq_mode == M_VECT) begin
            tgt_q <= AW'(data_bus);
            st <= S_LOAD;
          end else begin
            idx_q <= data_bus[IDXW-1:0];
            st <= S_TBL;
          end
        end
        S_TBL: begin
          from_tbl <= 1'b1;
          st <= S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign irq_ack    = (st == S_ACK);
  assign tbl_rd_en  = (st == S_TBL);
  assign tbl_addr   = TABLE_BASE + AW'(idx_q);
  assign load_pc    = (st == S_LOAD);
  assign target_pc  = from_tbl ? tbl_rd_data : tgt_q;
  assign busy       = (st != S_IDLE);
  assign save_pc    = save_q;
  assign saved_pc   = spc_q;
  assign int_masked = mask_q;

  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  a_r11_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_pc |-> busy);

  a_r5_read_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> (load_pc && !tbl_rd_en));

  a_r2_saved_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && instr_done && !ret && (nmi_pend || irq) && !in_nmi && (nmi_pend || !int_masked))
      |=> (save_pc && saved_pc == $past(pc_in)));

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && instr_done && !ret && !nmi_pend && int_masked) |=> (!save_pc && !busy));

  a_r7_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && instr_done && !ret && nmi_pend && !in_nmi)
      |=> (save_pc && load_pc && !irq_ack && target_pc == NMI_ADDR));
endmodule

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic mask_wr, mask_din, irq, nmi, instr_done, ret;
  logic [15:0] pc_in, data_bus, tbl_rd_data, tbl_addr, saved_pc, target_pc;
  logic irq_ack, tbl_rd_en, save_pc, load_pc, busy, int_masked;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mask_wr(mask_wr), .mask_din(mask_din),
    .irq(irq), .nmi(nmi), .instr_done(instr_done), .ret(ret), .pc_in(pc_in),
    .data_bus(data_bus), .tbl_rd_data(tbl_rd_data), .irq_ack(irq_ack),
    .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .save_pc(save_pc), .saved_pc(saved_pc),
    .load_pc(load_pc), .target_pc(target_pc), .busy(busy), .int_masked(int_masked)
  );

  always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= tbl_addr ^ 16'h5A30;

  typedef struct packed {
    logic [1:0]  m;
    logic        use_nmi;
    logic [15:0] pc;
    logic [15:0] bus;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'h0064, 16'h1111},
    '{2'd1, 1'b0, 16'h0200, 16'h0040},
    '{2'd2, 1'b0, 16'h0300, 16'hFF07},
    '{2'd2, 1'b0, 16'h0404, 16'h00FF},
    '{2'd1, 1'b1, 16'h0500, 16'h0777},
    '{2'd2, 1'b1, 16'h0608, 16'h0003}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic take(input logic [1:0] m, input logic use_nmi, input logic [15:0] pc,
                      input logic [15:0] bus, input logic keep_irq,
                      output int lat, output logic [15:0] tgt, output int acks,
                      output int saves, output logic [15:0] spc, output int bsy);
    mode = m;
    if (use_nmi) begin nmi = 1'b1; cyc(); nmi = 1'b0; end
    irq = !use_nmi || keep_irq;
    instr_done = 1'b1; pc_in = pc; data_bus = bus;
    cyc();
    instr_done = 1'b0;
    if (!keep_irq) irq = 1'b0;
    lat = 0; acks = 0; saves = 0; bsy = 0; tgt = '0; spc = '0;
    for (int i = 1; i <= 6; i++) begin
      if (irq_ack) acks++;
      if (busy) bsy++;
      if (save_pc) begin saves++; spc = saved_pc; end
      if (load_pc) begin lat = i; tgt = target_pc; break; end
      cyc();
    end
    cyc();
  endtask

  task automatic do_ret(output logic ld, output logic [15:0] tgt, output logic sv);
    ret = 1'b1; instr_done = 1'b1;
    cyc();
    ret = 1'b0; instr_done = 1'b0;
    ld = load_pc; tgt = target_pc; sv = save_pc;
    cyc();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, acks, saves, bsy;
    logic [15:0] tgt, spc, etgt;
    logic ld, sv;
    rst_n = 1'b0; mode = 2'd0; mask_wr = 0; mask_din = 0; irq = 0; nmi = 0;
    instr_done = 0; ret = 0; pc_in = '0; data_bus = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    chk("R11 reset busy", 16'(busy), 16'd0);
    chk("R11 reset outputs", {12'd0, irq_ack, load_pc, save_pc, tbl_rd_en}, 16'd0);
    chk("R6 reset mask", 16'(int_masked), 16'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      take(v.m, v.use_nmi, v.pc, v.bus, 1'b0, lat, tgt, acks, saves, spc, bsy);
      if (v.use_nmi) etgt = 16'd8;
      else if (v.m == 2'd0) etgt = 16'd16;
      else if (v.m == 2'd1) etgt = v.bus;
      else etgt = (16'h0100 + {8'd0, v.bus[7:0]}) ^ 16'h5A30;
      if (v.use_nmi) chk("R7 nmi target", tgt, etgt);
      else if (v.m == 2'd0) chk("R3 fixed target", tgt, etgt);
      else if (v.m == 2'd1) chk("R4 vector target", tgt, etgt);
      else chk("R5 table target", tgt, etgt);
      chk("R11 latency", 16'(lat), (v.use_nmi || v.m == 2'd0) ? 16'd1 : (v.m == 2'd1 ? 16'd2 : 16'd3));
      chk("R11 busy cycles", 16'(bsy), 16'(lat));
      chk("R4 ack count", 16'(acks), (!v.use_nmi && v.m != 2'd0) ? 16'd1 : 16'd0);
      chk("R2 save strobe", 16'(saves), 16'd1);
      chk("R2 saved pc", spc, v.pc);
      chk("R9 mask after entry", 16'(int_masked), v.use_nmi ? 16'd0 : 16'd1);
      do_ret(ld, tgt, sv);
      chk("R10 return load", 16'(ld), 16'd1);
      chk("R10 return target", tgt, v.pc);
      chk("R10 return no save", 16'(sv), 16'd0);
      chk("R9 mask restored", 16'(int_masked), 16'd0);
    end

    // R1: no boundary, no entry
    irq = 1'b1; mode = 2'd0;
    repeat (3) begin
      cyc();
      chk("R1 no boundary save", 16'(save_pc), 16'd0);
      chk("R1 no boundary busy", 16'(busy), 16'd0);
    end
    irq = 1'b0;

    // R6: software mask
    mask_wr = 1'b1; mask_din = 1'b1; cyc(); mask_wr = 1'b0;
    chk("R6 mask written", 16'(int_masked), 16'd1);
    irq = 1'b1; instr_done = 1'b1; pc_in = 16'h0A0A; cyc();
    instr_done = 1'b0;
    chk("R6 masked irq ignored save", 16'(save_pc), 16'd0);
    chk("R6 masked irq ignored busy", 16'(busy), 16'd0);
    irq = 1'b0; cyc();

    // R7: nmi taken while mask is set, mask untouched
    take(2'd1, 1'b1, 16'h0B00, 16'h1234, 1'b0, lat, tgt, acks, saves, spc, bsy);
    chk("R7 nmi when masked", tgt, 16'd8);
    chk("R7 nmi no ack", 16'(acks), 16'd0);
    do_ret(ld, tgt, sv);
    chk("R7 nmi return", tgt, 16'h0B00);
    chk("R9 nmi return keeps mask", 16'(int_masked), 16'd1);
    mask_wr = 1'b1; mask_din = 1'b0; cyc(); mask_wr = 1'b0;
    chk("R6 mask cleared", 16'(int_masked), 16'd0);

    // R8: nmi beats irq; irq follows after return
    take(2'd0, 1'b1, 16'h0C00, 16'h0000, 1'b1, lat, tgt, acks, saves, spc, bsy);
    chk("R8 nmi priority", tgt, 16'd8);
    do_ret(ld, tgt, sv);
    chk("R8 return from nmi", tgt, 16'h0C00);
    instr_done = 1'b1; pc_in = 16'h0C10; cyc(); instr_done = 1'b0; irq = 1'b0;
    chk("R8 irq after nmi load", 16'(load_pc), 16'd1);
    chk("R8 irq after nmi target", target_pc, 16'd16);
    cyc();

    // R9: auto mask holds off re-entry; nested nmi returns innermost first
    irq = 1'b1; instr_done = 1'b1; pc_in = 16'h0D00; cyc(); instr_done = 1'b0;
    chk("R9 still in first handler", saved_pc, 16'h0C10);
    cyc();
    do_ret(ld, tgt, sv);
    chk("R10 return to irq pc", tgt, 16'h0C10);
    instr_done = 1'b1; pc_in = 16'h0D00; cyc(); instr_done = 1'b0;
    chk("R9 entry with irq held", 16'(save_pc), 16'd1);
    cyc();
    instr_done = 1'b1; pc_in = 16'h0D04; cyc(); instr_done = 1'b0;
    chk("R9 no re-entry while masked", 16'(save_pc), 16'd0);
    irq = 1'b0;
    take(2'd0, 1'b1, 16'h0D08, 16'h0000, 1'b0, lat, tgt, acks, saves, spc, bsy);
    chk("R7 nested nmi", tgt, 16'd8);
    mask_wr = 1'b1; mask_din = 1'b0; irq = 1'b1; cyc(); mask_wr = 1'b0;
    instr_done = 1'b1; pc_in = 16'h0D0C; cyc(); instr_done = 1'b0; irq = 1'b0;
    chk("R9 irq blocked in nmi handler", 16'(save_pc), 16'd0);
    mask_wr = 1'b1; mask_din = 1'b1; cyc(); mask_wr = 1'b0;
    do_ret(ld, tgt, sv);
    chk("R10 nested return nmi first", tgt, 16'h0D08);
    do_ret(ld, tgt, sv);
    chk("R10 nested return irq second", tgt, 16'h0D00);
    chk("R9 mask restored after nest", 16'(int_masked), 16'd0);

    // R10: return with nothing active
    do_ret(ld, tgt, sv);
    chk("R10 stray return ignored", 16'(ld), 16'd0);
    chk("R10 stray return not busy", 16'(busy), 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule